// File: doc/BRIEF.md
# Performance Counter Bank with Negative-Condition Alert

This block holds six 32-bit event counters and one 64-bit control word. Software loads and reads any counter, the control word and an event-select word through a plain write port and a plain read port. Each counter advances by one on every clock in which its event input is high, unless it is frozen. The control word can freeze all counters at once, or freeze one of two groups: counters 1 to 4, or counters 5 and 6. The first four counters can also be switched to count every clock cycle by loading a fixed code into their select byte.

A counter is "negative" when its most significant bit is set, so any value of 0x80000000 or above. The control word holds one arming bit for counter 1 and one arming bit shared by counters 2 to 6. When an armed counter is negative, a sticky alert bit in the control word is set. The alert is also driven on its own output. When the exception-enable bit is set, an exception request output follows the alert. The condition is checked against the state that results from each clock edge. A write that loads a negative value into an armed counter, or a control write that arms a counter that is already negative, therefore raises the alert on that same edge. A counter that is not armed passes the sign threshold and wraps to zero with no alert.

Top module: `pmc_bank`

## Requirements
- R1: After synchronous reset, all counters, the control word and the select word read as zero, and `alert_o` and `exc_req_o` are low.
- R2: A write to address i (0 to 5) loads counter i+1 from `wr_data[31:0]`. Address 6 loads the 64-bit control word and address 7 loads the 32-bit select word. A read on `rd_addr` returns the value in `rd_data` with `rd_valid` high one clock later.
- R3: A counter that is not frozen advances by one on each clock edge where its event input is high. For counters 1 to 4, the value 0x1E in select byte `[8i+7:8i]` makes counter i+1 advance on every clock edge, whatever the event input.
- R4: Control bit 31 freezes all counters. Control bit 5 freezes only counters 1 to 4. Control bit 4 freezes only counters 5 and 6. Bit 0 is the least significant bit.
- R5: Control bit 15 arms the negative condition for counter 1 only. Control bit 14 arms it for counters 2 to 6 together.
- R6: On the clock edge where an armed counter counts from 0x7FFFFFFF up to 0x80000000, alert bit 7 of the control word and `alert_o` become 1. They are 0 on the edges before.
- R7: A write that loads a value of 0x80000000 or above into an armed counter raises the alert on that edge. So does a control write that arms a counter already holding such a value.
- R8: The alert is sticky. Counter changes do not clear it. A control write with bit 7 at 0 clears it, unless an armed counter is still negative in the new state.
- R9: `exc_req_o` is high exactly when the alert is set and control bit 20 is set.
- R10: A counter that is not armed counts past 0x80000000 and wraps from 0xFFFFFFFF to 0 without raising the alert.
- R11: When a counter write and an event increment land on the same clock edge, the written value is kept and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-5 counters, 6 control, 7 select |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | High the clock after a read strobe |
| evt_in | input | 6 | Per-counter event inputs, bit i for counter i+1 |
| alert_o | output | 1 | Sticky performance-monitor alert |
| exc_req_o | output | 1 | Exception request: alert gated by the exception enable |

## Verification
The sticky alert is computed from next-state values, so a wrong arming decode or a late comparison shows up on `alert_o` one clock after the crossing edge instead of on it. Counters are loaded just below the sign threshold and stepped one event at a time so that this one-edge offset can be seen. A freeze bit that gates the wrong group shows up as a counter that has moved by the exact number of event clocks, and it can be read back on the next read. A faulty write-versus-increment priority leaves the counter one above the loaded value.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // control word bit positions (bit 0 = least significant)
  localparam int unsigned CTL_W       = 64;
  localparam int unsigned B_FRZ_ALL   = 31;
  localparam int unsigned B_EXC_EN    = 20;
  localparam int unsigned B_ARM_FIRST = 15;
  localparam int unsigned B_ARM_REST  = 14;
  localparam int unsigned B_ALERT     = 7;
  localparam int unsigned B_FRZ_GA    = 5;
  localparam int unsigned B_FRZ_GB    = 4;
  // select code that turns a counter into a cycle counter
  localparam logic [7:0] CYC_CODE     = 8'h1E;
  localparam int unsigned SEL_BITS    = 8;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  // a load takes precedence over a pending increment
  always_comb begin
    if (wr_en)    cnt_nxt = wr_val;
    else if (inc) cnt_nxt = cnt_q + W'(1);
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R11: the loaded value survives a concurrent increment
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_q == $past(wr_val));
  // R3: one step per increment, no more
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && inc) |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned N    = 6,
  parameter int unsigned GRPA = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_val,
  input  logic [N-1:0]     neg_nxt,
  output logic [CTL_W-1:0] ctl_q,
  output logic [N-1:0]     frz,
  output logic             alert_o,
  output logic             exc_o
);
  logic [CTL_W-1:0] base;
  logic [CTL_W-1:0] ctl_nxt;
  logic [N-1:0]     armed_nxt;
  logic             hit;
  logic             exc_q;

  assign base = wr_en ? wr_val : ctl_q;

  // arming and freeze group decode, one lane per counter
  for (genvar i = 0; i < N; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign armed_nxt[i] = base[B_ARM_FIRST];
    end else begin : g_rest
      assign armed_nxt[i] = base[B_ARM_REST];
    end
    if (i < GRPA) begin : g_ga
      assign frz[i] = ctl_q[B_FRZ_ALL] | ctl_q[B_FRZ_GA];
    end else begin : g_gb
      assign frz[i] = ctl_q[B_FRZ_ALL] | ctl_q[B_FRZ_GB];
    end
  end

  assign hit = |(armed_nxt & neg_nxt);

  always_comb begin
    ctl_nxt          = base;
    ctl_nxt[B_ALERT] = base[B_ALERT] | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      exc_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      exc_q <= ctl_nxt[B_ALERT] & ctl_nxt[B_EXC_EN];
    end
  end

  assign alert_o = ctl_q[B_ALERT];
  assign exc_o   = exc_q;

  // R8: alert holds while software leaves the control word alone
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (alert_o && !wr_en) |=> alert_o);
  // R9: the request never appears without the alert
  a_r9_exc_needs_alert: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> alert_o);
  // R9: alert with enable always requests
  a_r9_exc_follows: assert property (@(posedge clk) disable iff (rst)
    (alert_o && ctl_q[B_EXC_EN]) |-> exc_o);
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned N_CTR  = 6,
  parameter int unsigned CTR_W  = 32,
  parameter int unsigned N_CYC  = 4,
  parameter int unsigned GRPA   = 4,
  parameter int unsigned ADDR_W = $clog2(N_CTR + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CTL_W-1:0]  rd_data,
  output logic              rd_valid,
  input  logic [N_CTR-1:0]  evt_in,
  output logic              alert_o,
  output logic              exc_req_o
);
  localparam int unsigned SEL_W    = SEL_BITS * N_CYC;
  localparam int unsigned A_CTL    = N_CTR;
  localparam int unsigned A_SEL    = N_CTR + 1;

  logic [N_CTR-1:0][CTR_W-1:0] cnt_q;
  logic [N_CTR-1:0][CTR_W-1:0] cnt_nxt;
  logic [N_CTR-1:0]            cnt_wr;
  logic [N_CTR-1:0]            cnt_inc;
  logic [N_CTR-1:0]            neg_nxt;
  logic [N_CTR-1:0]            frz;
  logic [CTL_W-1:0]            ctl_q;
  logic [SEL_W-1:0]            sel_q;
  logic                        ctl_wr;
  logic                        sel_wr;
  logic [CTL_W-1:0]            rd_mux;

  assign ctl_wr = wr_en && (wr_addr == ADDR_W'(A_CTL));
  assign sel_wr = wr_en && (wr_addr == ADDR_W'(A_SEL));

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_wr) sel_q <= wr_data[SEL_W-1:0];
  end

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    logic src;
    if (i < N_CYC) begin : g_cyc
      assign src = evt_in[i] | (sel_q[SEL_BITS*i +: SEL_BITS] == CYC_CODE);
    end else begin : g_evt
      assign src = evt_in[i];
    end
    assign cnt_wr[i]  = wr_en && (wr_addr == ADDR_W'(i));
    assign cnt_inc[i] = src && !frz[i];
    assign neg_nxt[i] = cnt_nxt[i][CTR_W-1];

    pmc_counter #(.W(CTR_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cnt_wr[i]),
      .wr_val  (wr_data[CTR_W-1:0]),
      .inc     (cnt_inc[i]),
      .cnt_q   (cnt_q[i]),
      .cnt_nxt (cnt_nxt[i])
    );

    // R4: a frozen counter that is not written does not move
    a_r4_frozen_hold: assert property (@(posedge clk) disable iff (rst)
      (frz[i] && !cnt_wr[i]) |=> $stable(cnt_q[i]));
    // R6: an armed negative counter always shows as an alert
    a_r6_armed_neg: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[i][CTR_W-1] &&
       ((i == 0) ? ctl_q[B_ARM_FIRST] : ctl_q[B_ARM_REST])) |-> alert_o);
  end

  pmc_ctrl #(.N(N_CTR), .GRPA(GRPA)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctl_wr),
    .wr_val  (wr_data),
    .neg_nxt (neg_nxt),
    .ctl_q   (ctl_q),
    .frz     (frz),
    .alert_o (alert_o),
    .exc_o   (exc_req_o)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(A_CTL))      rd_mux = ctl_q;
    else if (rd_addr == ADDR_W'(A_SEL)) rd_mux = CTL_W'(sel_q);
    else begin
      for (int k = 0; k < N_CTR; k++)
        if (rd_addr == ADDR_W'(k)) rd_mux = CTL_W'(cnt_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2: read data is presented exactly one clock after the strobe
  a_r2_rd_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/pmc_bank_tb_top.sv
module pmc_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic [5:0]  evt_in = '0;
  logic        alert_o;
  logic        exc_req_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q[$];
  string       req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .evt_in(evt_in), .alert_o(alert_o), .exc_req_o(exc_req_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  // driver: push the expected value, strobe the read
  task automatic rd(input logic [2:0] a, input logic [63:0] e, input string req);
    exp_q.push_back(e); req_q.push_back(req);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  // monitor: compare results as they come out
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 64'h1, 64'h0);
      else chk(req_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 alert", alert_o, 0);
    chk("R1 exc", exc_req_o, 0);
    for (int a = 0; a < 8; a++) rd(3'(a), 64'h0, "R1 reg");

    // R2 write/read, upper bits ignored for counters
    wr(3'd1, 64'hDEAD_0000_1234_5678);
    rd(3'd1, 64'h1234_5678, "R2 counter load");
    // R3 event counting
    evt_in = 6'b000010; repeat (5) tick(); evt_in = '0;
    rd(3'd1, 64'h1234_567D, "R3 event count");
    // R3 cycle code on counter 1
    wr(3'd7, 64'h1E);
    wr(3'd0, 64'd100);
    repeat (10) tick();
    wr(3'd6, 64'h8000_0000);   // freeze all, this edge still counts
    wr(3'd7, 64'h0);
    rd(3'd0, 64'd111, "R3 cycle code");
    rd(3'd7, 64'h0, "R2 select readback");

    // R4 freezes
    for (int i = 0; i < 6; i++) wr(3'(i), 64'(i*16));
    evt_in = 6'h3F; repeat (3) tick(); evt_in = '0;
    rd(3'd0, 64'd0, "R4 freeze all c1");
    rd(3'd5, 64'd80, "R4 freeze all c6");
    wr(3'd6, 64'h20);
    evt_in = 6'h3F; repeat (3) tick(); evt_in = '0;
    rd(3'd1, 64'd16, "R4 group A frozen");
    rd(3'd4, 64'd67, "R4 group B runs");
    wr(3'd6, 64'h10);
    evt_in = 6'h3F; repeat (2) tick(); evt_in = '0;
    rd(3'd2, 64'd34, "R4 group A runs");
    rd(3'd5, 64'd83, "R4 group B frozen");

    // R6 crossing on counter 1
    wr(3'd6, 64'h8000);
    wr(3'd0, 64'h7FFF_FFFD);
    evt_in = 6'b000001;
    tick(); tick();
    chk("R6 no alert before crossing", alert_o, 0);
    tick();
    evt_in = '0;
    chk("R6 alert on crossing", alert_o, 1);
    chk("R9 exc disabled", exc_req_o, 0);
    rd(3'd0, 64'h8000_0000, "R6 counter at threshold");
    rd(3'd6, 64'h8080, "R6 alert bit in control");
    // R9 / R8
    wr(3'd6, 64'h10_8000);
    chk("R8 clear blocked while negative", alert_o, 1);
    chk("R9 exc asserted", exc_req_o, 1);
    wr(3'd0, 64'd5);
    chk("R8 sticky after counter load", alert_o, 1);
    wr(3'd6, 64'h8000);
    chk("R8 cleared", alert_o, 0);
    chk("R9 exc cleared", exc_req_o, 0);
    // R7 immediate on write
    wr(3'd0, 64'h9000_0000);
    chk("R7 write negative armed", alert_o, 1);
    wr(3'd6, 64'h0);
    chk("R8 clear disarmed", alert_o, 0);
    // R5 shared arm does not cover counter 1
    wr(3'd6, 64'h4000);
    chk("R5 c1 not armed by shared bit", alert_o, 0);
    wr(3'd3, 64'h8000_0001);
    chk("R5 c4 armed by shared bit", alert_o, 1);
    wr(3'd6, 64'h0);
    chk("R8 clear again", alert_o, 0);
    wr(3'd6, 64'h4000);
    chk("R7 arm with negative counter", alert_o, 1);
    wr(3'd6, 64'h0);

    // R10 unarmed wrap
    wr(3'd2, 64'hFFFF_FFFE);
    evt_in = 6'b000100; repeat (3) tick(); evt_in = '0;
    rd(3'd2, 64'd1, "R10 wrap");
    chk("R10 no alert", alert_o, 0);

    // R11 write wins over increment
    evt_in = 6'b010000;
    wr(3'd4, 64'd7);
    evt_in = '0;
    rd(3'd4, 64'd7, "R11 write wins");

    tick(); tick();
    chk("R2 all reads returned", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule